// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Generator with Stepped Soft Start

This block produces the gate-drive bit of a current-mode switching regulator from a fast system clock. A phase counter defines each switching period. Every period starts by setting a PWM latch. The latch is cleared by whichever comes first: an external PWM-comparator flag, a current-limit flag, or the on-time ceiling. At the default parameters the clock is 10 MHz and the period is 100 cycles, which gives 100 kHz. The on-time ceiling is three quarters of the period, and the current-limit flag is blanked for the first cycles of every on-time.

After enable, or after a restart request, the block runs a soft start. The ceiling rises in equal steps of a fixed length. At the defaults these are 32 steps of 600 µs, about 19.2 ms in total. During soft start the period stays at its nominal length. Once the last step ends, the period is swept in a triangle one cycle at a time, to ±4 cycles around nominal (±4 kHz). Each cycle is held for a fixed number of periods, so that one full sweep lasts 4 ms. The enable input comes from undervoltage lockout. While it is low, the gate is forced low and all sequencing returns to its starting point. Other blocks use the soft-start flag and the blanking window.

Top module: `jitter_pwm_gen`

## Requirements
- R1: During reset, gate_o and blank_o are 0 and ss_active_o is 1.
- R2: When en_i is low at a clock edge, gate_o is 0 after that edge and ss_active_o is 1. The soft start restarts from step zero once en_i returns.
- R3: After the first enabled edge, the gate first rises PER_NOM edges later. During soft start every period is exactly PER_NOM cycles.
- R4: Soft start step k (0-based) limits the on-time to floor((k+1)*MAXON_NOM/SS_STEPS) cycles, where MAXON_NOM = floor(PER_NOM*3/4) and SS_STEPS is a power of two. Each step lasts SS_STEP_CYC cycles. ss_active_o falls SS_STEPS*SS_STEP_CYC edges after enable.
- R5: After soft start, an undisturbed pulse is high for floor(3P/4) cycles, where P is the length of its own period.
- R6: After soft start, the period moves by one cycle every JIT_DWELL periods. It starts at PER_NOM and moves upward, then turns at PER_NOM+JIT_DEV and at PER_NOM-JIT_DEV.
- R7: pwm_off_i sampled high while the gate is high makes the gate low after that edge.
- R8: ilim_i is ignored while blank_o is high. Outside that window, ilim_i sampled high while the gate is high makes the gate low after that edge.
- R9: blank_o is high exactly during the first LEB_CYC cycles of each on-time, and only while gate_o is high.
- R10: A restart_i pulse acts like an enable drop. The gate goes low, soft start begins again from step zero, and the period returns to PER_NOM.
- R11: The edge that starts a period always sets the gate, whatever pwm_off_i does in that cycle. A pwm_off_i held high therefore gives one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Supply above undervoltage lockout |
| pwm_off_i | input | 1 | PWM comparator reset request |
| ilim_i | input | 1 | Current-limit trip |
| restart_i | input | 1 | Re-enter soft start |
| gate_o | output | 1 | Gate drive bit |
| ss_active_o | output | 1 | Soft start in progress |
| blank_o | output | 1 | Leading-edge blanking window |

## Verification
The frequency sweep only begins after the full soft start, and its turning points arrive many periods later. The bench therefore shrinks the block: a 20-cycle period, four 30-cycle steps, ±2 cycles of sweep and two periods per sweep step. This reaches both ends of the sweep within a few hundred cycles. A trip inside the blanking window must fall in the first cycles after a rising gate, so the bench first waits for a rise and then drives ilim_i in that same cycle. A per-cycle model follows every output throughout.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;
  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DN = 1'b1} sweep_e;

  function automatic int unsigned duty_cap(input int unsigned per,
                                           input int unsigned num,
                                           input int unsigned sh);
    return (per * num) >> sh;
  endfunction
endpackage

// File: rtl/pwmj_phase.sv
// Period counter with optional triangular period sweep and per-period duty cap.
module pwmj_phase
  import pwmj_pkg::*;
#(
  parameter int PER_NOM   = 100,
  parameter int JIT_DEV   = 4,
  parameter int JIT_DWELL = 25,
  parameter int DUTY_NUM  = 3,
  parameter int DUTY_SH   = 2,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          jit_en,
  output logic [CW-1:0] ph,
  output logic          wrap,
  output logic [CW-1:0] on_cap
);
  localparam int DW = (JIT_DWELL > 1) ? $clog2(JIT_DWELL) : 1;
  localparam int PW = CW + $clog2(DUTY_NUM + 1);

  logic [CW-1:0] per_q;
  logic [PW-1:0] prod;

  assign wrap   = (ph == per_q - CW'(1));
  assign prod   = PW'(per_q) * PW'(DUTY_NUM);
  assign on_cap = CW'(prod >> DUTY_SH);

  always_ff @(posedge clk) begin
    if (clr)       ph <= '0;
    else if (wrap) ph <= '0;
    else           ph <= ph + CW'(1);
  end

  generate
    if (JIT_DEV == 0) begin : g_fixed
      assign per_q = CW'(PER_NOM);
    end else begin : g_sweep
      localparam logic [CW-1:0] PMAX = CW'(PER_NOM + JIT_DEV);
      localparam logic [CW-1:0] PMIN = CW'(PER_NOM - JIT_DEV);
      sweep_e        dir_q;
      logic [DW-1:0] dwell_q;
      logic [CW-1:0] per_r;

      always_ff @(posedge clk) begin
        if (clr) begin
          per_r   <= CW'(PER_NOM);
          dir_q   <= SWEEP_UP;
          dwell_q <= '0;
        end else if (jit_en && wrap) begin
          if (dwell_q == DW'(JIT_DWELL - 1)) begin
            dwell_q <= '0;
            if (dir_q == SWEEP_UP) begin
              per_r <= per_r + CW'(1);
              if (per_r + CW'(1) == PMAX) dir_q <= SWEEP_DN;
            end else begin
              per_r <= per_r - CW'(1);
              if (per_r - CW'(1) == PMIN) dir_q <= SWEEP_UP;
            end
          end else begin
            dwell_q <= dwell_q + DW'(1);
          end
        end
      end
      assign per_q = per_r;
    end
  endgenerate
endmodule

// File: rtl/pwmj_softstart.sv
// Stepped on-time ceiling that rises once per step interval.
module pwmj_softstart #(
  parameter int SS_STEPS    = 32,
  parameter int SS_STEP_CYC = 6000,
  parameter int MAXON_NOM   = 75,
  parameter int CW          = 7
) (
  input  logic          clk,
  input  logic          clr,
  output logic          active,
  output logic [CW-1:0] ss_cap
);
  localparam int SW = $clog2(SS_STEPS);
  localparam int TW = (SS_STEP_CYC > 1) ? $clog2(SS_STEP_CYC) : 1;
  localparam int MW = CW + SW + 1;

  logic [SW-1:0] step_q;
  logic [TW-1:0] tmr_q;
  logic [MW-1:0] prod;

  always_ff @(posedge clk) begin
    if (clr) begin
      tmr_q  <= '0;
      step_q <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (tmr_q == TW'(SS_STEP_CYC - 1)) begin
        tmr_q <= '0;
        if (step_q == SW'(SS_STEPS - 1)) active <= 1'b0;
        else                             step_q <= step_q + SW'(1);
      end else begin
        tmr_q <= tmr_q + TW'(1);
      end
    end
  end

  assign prod   = (MW'(step_q) + MW'(1)) * MW'(MAXON_NOM);
  assign ss_cap = CW'(prod >> SW);
endmodule

// File: rtl/pwmj_latch.sv
// Set-dominant PWM latch with leading-edge blanking of the current-limit trip.
module pwmj_latch #(
  parameter int CW      = 7,
  parameter int LEB_CYC = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wrap,
  input  logic [CW-1:0] ph,
  input  logic [CW-1:0] cap,
  input  logic          trip_pwm,
  input  logic          trip_ilim,
  output logic          gate_q,
  output logic          blank_q
);
  logic [CW-1:0] ph_nx;
  logic          ilim_live, end_on, gate_nx, blank_nx;

  assign ph_nx     = wrap ? '0 : ph + CW'(1);
  assign ilim_live = trip_ilim & ~blank_q;
  assign end_on    = trip_pwm | ilim_live | (ph_nx >= cap);
  assign gate_nx   = wrap | (gate_q & ~end_on);

  generate
    if (LEB_CYC == 0) begin : g_noblank
      assign blank_nx = 1'b0;
    end else begin : g_blank
      assign blank_nx = gate_nx & (ph_nx < CW'(LEB_CYC));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      gate_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      gate_q  <= gate_nx;
      blank_q <= blank_nx;
    end
  end
endmodule

// File: rtl/jitter_pwm_gen.sv
module jitter_pwm_gen
  import pwmj_pkg::*;
#(
  parameter int PER_NOM     = 100,
  parameter int JIT_DEV     = 4,
  parameter int JIT_DWELL   = 25,
  parameter int DUTY_NUM    = 3,
  parameter int DUTY_SH     = 2,
  parameter int SS_STEPS    = 32,
  parameter int SS_STEP_CYC = 6000,
  parameter int LEB_CYC     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic pwm_off_i,
  input  logic ilim_i,
  input  logic restart_i,
  output logic gate_o,
  output logic ss_active_o,
  output logic blank_o
);
  localparam int CW        = $clog2(PER_NOM + JIT_DEV + 1);
  localparam int MAXON_NOM = int'(duty_cap(PER_NOM, DUTY_NUM, DUTY_SH));

  logic          clr, wrap, ss_act;
  logic [CW-1:0] ph, on_cap, ss_cap, lim;

  assign clr = rst | ~en_i | restart_i;

  pwmj_phase #(
    .PER_NOM(PER_NOM), .JIT_DEV(JIT_DEV), .JIT_DWELL(JIT_DWELL),
    .DUTY_NUM(DUTY_NUM), .DUTY_SH(DUTY_SH), .CW(CW)
  ) u_phase (
    .clk(clk), .clr(clr), .jit_en(~ss_act),
    .ph(ph), .wrap(wrap), .on_cap(on_cap)
  );

  pwmj_softstart #(
    .SS_STEPS(SS_STEPS), .SS_STEP_CYC(SS_STEP_CYC),
    .MAXON_NOM(MAXON_NOM), .CW(CW)
  ) u_ss (
    .clk(clk), .clr(clr), .active(ss_act), .ss_cap(ss_cap)
  );

  assign lim = ss_act ? ss_cap : on_cap;

  pwmj_latch #(.CW(CW), .LEB_CYC(LEB_CYC)) u_latch (
    .clk(clk), .clr(clr), .wrap(wrap), .ph(ph), .cap(lim),
    .trip_pwm(pwm_off_i), .trip_ilim(ilim_i),
    .gate_q(gate_o), .blank_q(blank_o)
  );

  assign ss_active_o = ss_act;
endmodule

// File: rtl/pwmj_chk.sv
module pwmj_chk #(
  parameter int PER_NOM  = 100,
  parameter int JIT_DEV  = 4,
  parameter int DUTY_NUM = 3,
  parameter int DUTY_SH  = 2,
  parameter int LEB_CYC  = 2
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic restart_i,
  input logic gate_o,
  input logic ss_active_o,
  input logic blank_o
);
  localparam int ONCAP = ((PER_NOM + JIT_DEV) * DUTY_NUM) >> DUTY_SH;
  logic [15:0] on_cnt;

  always_ff @(posedge clk) begin
    if (rst)         on_cnt <= '0;
    else if (gate_o) on_cnt <= on_cnt + 16'd1;
    else             on_cnt <= '0;
  end

  // R2
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!gate_o && ss_active_o));
  // R10
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (!gate_o && ss_active_o));
  // R9
  a_r9_blank_inside_gate: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> gate_o);
  // R9 / R11
  a_r9_rise_is_blanked: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> (blank_o || (LEB_CYC == 0)));
  // R5
  a_r5_on_time_bound: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> (int'(on_cnt) < ONCAP));
  // R4
  a_r4_ss_rearm_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_active_o) |-> $past(!en_i || restart_i));
endmodule

bind jitter_pwm_gen pwmj_chk #(
  .PER_NOM(PER_NOM), .JIT_DEV(JIT_DEV), .DUTY_NUM(DUTY_NUM),
  .DUTY_SH(DUTY_SH), .LEB_CYC(LEB_CYC)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .restart_i(restart_i),
  .gate_o(gate_o), .ss_active_o(ss_active_o), .blank_o(blank_o)
);

// File: tb/tb_jitter_pwm_gen.sv
module tb_jitter_pwm_gen;
  localparam int P   = 20;
  localparam int JD  = 2;
  localparam int JW  = 2;
  localparam int SSN = 4;
  localparam int SSC = 30;
  localparam int LEB = 3;
  localparam int MXN = (P * 3) / 4;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, pwm_off = 1'b0, ilim = 1'b0, restart = 1'b0;
  logic gate, ss_act, blank;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  jitter_pwm_gen #(
    .PER_NOM(P), .JIT_DEV(JD), .JIT_DWELL(JW),
    .SS_STEPS(SSN), .SS_STEP_CYC(SSC), .LEB_CYC(LEB)
  ) dut (
    .clk(clk), .rst(rst), .en_i(en), .pwm_off_i(pwm_off), .ilim_i(ilim),
    .restart_i(restart), .gate_o(gate), .ss_active_o(ss_act), .blank_o(blank)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural reference model
  int m_ph = 0, m_per = P, m_dir = 1, m_dwell = 0, m_sst = 0, m_step = 0;
  bit m_gate = 0, m_blank = 0, m_act = 1;

  always @(posedge clk) begin : model
    int lim, nph;
    bit wr, ng;
    if (rst || !en || restart) begin
      m_ph = 0; m_per = P; m_dir = 1; m_dwell = 0; m_sst = 0; m_step = 0;
      m_act = 1; m_gate = 0; m_blank = 0;
    end else begin
      lim = m_act ? ((m_step + 1) * MXN) / SSN : (m_per * 3) / 4;
      wr  = (m_ph == m_per - 1);
      nph = wr ? 0 : m_ph + 1;
      if (wr) ng = 1;
      else if (m_gate && (pwm_off || (ilim && m_ph >= LEB) || nph >= lim)) ng = 0;
      else ng = m_gate;
      if (wr && !m_act) begin
        if (m_dwell == JW - 1) begin
          m_dwell = 0;
          m_per = m_per + m_dir;
          if (m_per == P + JD) m_dir = -1;
          else if (m_per == P - JD) m_dir = 1;
        end else m_dwell++;
      end
      if (m_act) begin
        if (m_sst == SSC - 1) begin
          m_sst = 0;
          if (m_step == SSN - 1) m_act = 0; else m_step++;
        end else m_sst++;
      end
      m_ph = nph; m_gate = ng; m_blank = ng && (nph < LEB);
    end
  end

  task automatic cmp(input logic a, input bit e, input string tag);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, a, e);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    cmp(gate,   m_gate,  "R5 gate_o vs model");
    cmp(blank,  m_blank, "R9 blank_o vs model");
    cmp(ss_act, m_act,   "R4 ss_active_o vs model");
  end

  task automatic next_pulse(output int t, output int w);
    @(negedge clk);
    while (gate) @(negedge clk);
    while (!gate) @(negedge clk);
    t = cyc; w = 0;
    while (gate) begin w++; @(negedge clk); end
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (gate) @(negedge clk);
    while (!gate) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int c0, t, w, tp, wp, pmin, pmax;
    repeat (4) @(negedge clk);
    chk("R1 reset gate", int'(gate), 0);
    chk("R1 reset blank", int'(blank), 0);
    chk("R1 reset ss_active", int'(ss_act), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle while disabled", int'(gate), 0);

    // R3 / R4: first pulse timing and soft-start steps
    c0 = cyc; en = 1'b1;
    next_pulse(t, w);
    chk("R3 first rise delay", t - c0, P);
    chk("R4 step0 width", w, (1 * MXN) / SSN);
    next_pulse(tp, wp);
    chk("R3 soft-start period", tp - t, P);
    chk("R4 step1 width", wp, (2 * MXN) / SSN);
    while (cyc != c0 + SSN * SSC - 1) @(negedge clk);
    chk("R4 ss_active before end", int'(ss_act), 1);
    @(negedge clk);
    chk("R4 ss_active after end", int'(ss_act), 0);

    // R5 / R6: sweep
    pmin = 1000; pmax = 0;
    next_pulse(tp, wp);
    for (int i = 0; i < 40; i++) begin
      next_pulse(t, w);
      if (t - tp < pmin) pmin = t - tp;
      if (t - tp > pmax) pmax = t - tp;
      chk("R5 width vs own period", wp, ((t - tp) * 3) / 4);
      tp = t; wp = w;
    end
    chk("R6 minimum period", pmin, P - JD);
    chk("R6 maximum period", pmax, P + JD);

    // R7: comparator reset mid-pulse
    wait_rise();
    repeat (4) @(negedge clk);
    pwm_off = 1'b1;
    @(negedge clk);
    chk("R7 gate after pwm_off", int'(gate), 0);
    pwm_off = 1'b0;

    // R11: set dominates held comparator
    @(negedge clk);
    pwm_off = 1'b1;
    while (!gate) @(negedge clk);
    chk("R11 gate set despite pwm_off", int'(gate), 1);
    @(negedge clk);
    chk("R11 one-cycle pulse", int'(gate), 0);
    pwm_off = 1'b0;

    // R8 / R9: blanking window
    wait_rise();
    chk("R9 blank at rise", int'(blank), 1);
    ilim = 1'b1;
    repeat (LEB) @(negedge clk);
    chk("R8 ilim ignored in window", int'(gate), 1);
    chk("R9 blank ends after LEB", int'(blank), 0);
    @(negedge clk);
    chk("R8 ilim trips after window", int'(gate), 0);
    ilim = 1'b0;

    // R10: restart
    wait_rise();
    @(negedge clk);
    c0 = cyc; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R10 gate cleared", int'(gate), 0);
    chk("R10 ss_active set", int'(ss_act), 1);
    next_pulse(t, w);
    chk("R10 first rise after restart", t - c0, P + 1);
    chk("R10 width from step zero", w, MXN / SSN);
    next_pulse(tp, wp);
    chk("R10 nominal period", tp - t, P);

    // R2: enable drop
    wait_rise();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R2 gate low when disabled", int'(gate), 0);
    chk("R2 ss_active when disabled", int'(ss_act), 1);
    repeat (5) @(negedge clk);
    c0 = cyc; en = 1'b1;
    next_pulse(t, w);
    chk("R2 rise after re-enable", t - c0, P);
    chk("R2 soft start from zero", w, MXN / SSN);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule